// File: doc/BRIEF.md
# Auto-Increment String Constants Port

This block keeps a small table of constant bytes, chiefly zero-terminated text, for a small I/O processor. The processor sees the whole table through a single peripheral address. Writing to that address sets an internal 8-bit pointer to a chosen start location. Each read from the same address returns the byte under the pointer, and the pointer then moves on by one. Software can therefore print a message by loading its start offset once. It then reads one character at a time until it gets a zero byte.

The block decodes the peripheral address itself and qualifies the bus write and read strobes with that decode. It drives its byte onto the read-data output only while its own address is presented. The table contents are part of the design code. It holds three labelled messages and a short tail at the top of the address space, and every other location reads as zero.

Top module: `str_const_port`

## Requirements
- R1: After reset the pointer is 0x00, so with the port address presented and no strobe the output shows the byte at offset 0x00 ('H', 0x48).
- R2: A write cycle (bus_wr high) at the port address (0x0E) loads the pointer with bus_wdata on that clock edge.
- R3: While the port address is presented, rd_data shows the byte under the pointer. A read cycle (bus_rd high) at the port address advances the pointer by one on that clock edge, so back-to-back reads return consecutive bytes.
- R4: Advancing from pointer 0xFF gives 0x00, so a read after the byte at 0xFF returns the byte at 0x00.
- R5: When bus_wr and bus_rd are both high at the port address in one cycle, the pointer takes bus_wdata and is not incremented.
- R6: Strobes at any address other than 0x0E leave the pointer unchanged, and rd_data is 0x00 whenever the address is not 0x0E.
- R7: In cycles with neither strobe at the port address, the pointer holds its value.
- R8: The table holds "HELLO" at 0x00, "READY>" at 0x10 and "ERR 42" at 0x20, each followed by a 0x00 byte. Offset 0xFE holds 'Z' (0x5A) and 0xFF holds '!' (0x21). All other offsets hold 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Peripheral address from the processor |
| bus_wr | input | 1 | Peripheral write strobe |
| bus_rd | input | 1 | Peripheral read strobe |
| bus_wdata | input | 8 | Peripheral write data (pointer start value) |
| rd_data | output | 8 | Byte under the pointer when the port is addressed, else zero |

## Verification
The bench walks each stored message from its start offset to the terminator. It checks every character and the position of the zero, so a pointer that skips or repeats a step shows up as a wrong character or a misplaced terminator. It reads across the top of the table to catch a pointer that saturates or runs past 0xFF instead of wrapping to 'H'. It issues load and read together to catch a design that increments after loading, which would leave the next read one byte late. It also strobes a neighbouring address to catch a design that decodes loosely and moves the pointer or drives the bus.

// File: rtl/str_const_port.sv
module str_const_port #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          BUS_AW    = 8,
  parameter logic [7:0]  PORT_ADDR = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     rd_data
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  logic [AW-1:0] ptr;
  logic          sel, load_en, step_en;

  assign sel     = (bus_addr == BUS_AW'(PORT_ADDR));
  assign load_en = sel && bus_wr;
  assign step_en = sel && bus_rd && !bus_wr;

  function automatic logic [DW-1:0] table_byte(input logic [AW-1:0] a);
    logic [7:0] v;
    case (8'(a))
      8'h00: v = "H";
      8'h01: v = "E";
      8'h02: v = "L";
      8'h03: v = "L";
      8'h04: v = "O";
      8'h10: v = "R";
      8'h11: v = "E";
      8'h12: v = "A";
      8'h13: v = "D";
      8'h14: v = "Y";
      8'h15: v = ">";
      8'h20: v = "E";
      8'h21: v = "R";
      8'h22: v = "R";
      8'h23: v = " ";
      8'h24: v = "4";
      8'h25: v = "2";
      8'hFE: v = "Z";
      8'hFF: v = "!";
      default: v = 8'h00;
    endcase
    return DW'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load_en) ptr <= AW'(bus_wdata);
    else if (step_en) ptr <= ptr + PTR_ONE;
  end

  assign rd_data = sel ? table_byte(ptr) : '0;
endmodule

// File: rtl/str_const_port_chk.sv
module str_const_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] rd_data,
  input logic [7:0] ptr
);
  a_r1_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> ptr == 8'h00);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h0E && bus_wr) |=> ptr == $past(bus_wdata));
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h0E && bus_rd && !bus_wr) |=> ptr == 8'($past(ptr) + 8'd1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h0E && bus_rd && !bus_wr && ptr == 8'hFF) |=> ptr == 8'h00);
  a_r6_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 8'h0E) |=> $stable(ptr));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> $stable(ptr));
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 8'h0E) |-> rd_data == 8'h00);
endmodule

bind str_const_port str_const_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data), .ptr(ptr)
);

// File: tb/str_const_port_tb.sv
module str_const_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_ptr = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         sample_now = 1'b0;

  always #4 clk = ~clk;

  str_const_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data)
  );

  function automatic logic [7:0] ref_byte(input logic [7:0] a);
    string s0 = "HELLO", s1 = "READY>", s2 = "ERR 42";
    if (a < 8'h10) return (a < 8'(s0.len())) ? 8'(s0[a]) : 8'h00;
    if (a >= 8'h10 && a < 8'h20) return (a - 8'h10 < 8'(s1.len())) ? 8'(s1[a-8'h10]) : 8'h00;
    if (a >= 8'h20 && a < 8'h30) return (a - 8'h20 < 8'(s2.len())) ? 8'(s2[a-8'h20]) : 8'h00;
    if (a == 8'hFE) return 8'h5A;
    if (a == 8'hFF) return 8'h21;
    return 8'h00;
  endfunction

  task automatic bus_op(input logic [7:0] a, input logic w, input logic r,
                        input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    exp_q.push_back(a == 8'h0E ? ref_byte(m_ptr) : 8'h00);
    tag_q.push_back(tag);
    sample_now = 1'b1;
    if (a == 8'h0E) begin
      if (w)      m_ptr = d;
      else if (r) m_ptr = m_ptr + 8'd1;
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (sample_now) begin
      logic [7:0] e;
      string t;
      sample_now = 1'b0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  task automatic walk(input logic [7:0] start, input int exp_len, input string tag);
    int len = 0;
    bus_op(8'h0E, 1'b1, 1'b0, start, tag);
    while (ref_byte(m_ptr) != 8'h00 && len < 40) begin
      bus_op(8'h0E, 1'b0, 1'b1, 8'h00, tag);
      len++;
    end
    bus_op(8'h0E, 1'b0, 1'b1, 8'h00, {tag, " terminator"});
    n_tests++;
    if (len != exp_len) begin
      n_fail++;
      $display("FAIL %s: length=%0d expected=%0d", tag, len, exp_len);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_op(8'h0E, 1'b0, 1'b0, 8'h00, "R1 reset pointer");
    walk(8'h00, 5, "R8 R3 msg0");
    walk(8'h10, 6, "R8 R3 msg1");
    walk(8'h20, 6, "R8 R3 msg2");
    bus_op(8'h0E, 1'b1, 1'b0, 8'hFE, "R2 load FE");
    bus_op(8'h0E, 1'b0, 1'b1, 8'h00, "R3 read FE");
    bus_op(8'h0E, 1'b0, 1'b1, 8'h00, "R4 read FF");
    bus_op(8'h0E, 1'b0, 1'b1, 8'h00, "R4 wrapped to 00");
    bus_op(8'h0E, 1'b1, 1'b1, 8'h10, "R5 load+read same cycle");
    bus_op(8'h0E, 1'b0, 1'b0, 8'h00, "R5 pointer at 10 not 11");
    bus_op(8'h0D, 1'b0, 1'b1, 8'h00, "R6 foreign read output zero");
    bus_op(8'h0D, 1'b1, 1'b0, 8'h20, "R6 foreign write output zero");
    bus_op(8'h0F, 1'b0, 1'b1, 8'h00, "R6 foreign read 0F");
    bus_op(8'h0E, 1'b0, 1'b0, 8'h00, "R6 pointer untouched");
    repeat (3) bus_op(8'h0E, 1'b0, 1'b0, 8'h00, "R7 hold without strobe");
    bus_op(8'h0E, 1'b1, 1'b0, 8'h30, "R8 blank region");
    bus_op(8'h0E, 1'b0, 1'b1, 8'h00, "R8 blank 30");
    bus_op(8'h0E, 1'b0, 1'b0, 8'h00, "R8 blank 31");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule